// File: doc/BRIEF.md
# Exception Pending and Control Register Slice

This block is the system-control register slice of a nested vectored interrupt controller. It keeps a pending bit and an active bit for each implemented system exception and for each external interrupt. Three faults (memory-manage, bus, usage) can be turned on or off through enable bits. Software reaches the state through a small word-addressed register bus. It can raise and retire exceptions, read back a packed control/state word, program a vector table base and issue keyed reset-control commands.

The processor side reports the vector it is running (`cpu_active_vec`, 0 for thread mode). It pulses `ack` to take the offered exception and pulses `done` with a vector number to retire it. Arbitration is simplified: among pending exceptions that are enabled, the lowest vector number wins. Vector numbers are fixed as follows:

| Exception | Vector |
|---|---|
| NMI | 2 |
| memory-manage | 4 |
| bus fault | 5 |
| usage fault | 6 |
| SVC | 11 |
| debug monitor | 12 |
| PendSV | 14 |
| tick | 15 |
| external interrupt N | N+16 |

Top module: `exc_ctrl_regs`

## Requirements
- R1: After reset nothing is pending or active and `pend_valid` is 0. The control/state word (offset 0x04) then reads 0x00000800. The type word (offset 0x00) reads N_EXT/32-1, which is 1 at the default of 64 external interrupts.
- R2: A write to offset 0x04 sets or clears pending bits. Bit 31 sets NMI pending. Bit 28 sets PendSV pending; otherwise bit 27 clears it. Bit 26 sets tick pending; otherwise bit 25 clears it. A set always wins over a clear that lands in the same cycle.
- R3: A read of offset 0x04 returns the following fields. Bits [8:0] hold `cpu_active_vec`. Bits [20:12] hold the offered pending vector, or 0 when none is offered. Bit 22 is set when any external interrupt is pending. Bits 26, 28 and 31 show tick, PendSV and NMI pending.
- R4: Bit 11 of the control/state word is 1 exactly when no vector other than `cpu_active_vec` has its active bit set.
- R5: `pend_vec` is the lowest-numbered exception that is both pending and enabled, and `pend_valid` shows whether one exists. Memory-manage, bus and usage count as enabled only when their enable bits are set; every other exception is always enabled. `ack` moves the offered vector from pending to active. `done` clears the active bit of `done_vec`. Bit v of `sys_raise` sets vector v pending, for implemented system vectors only. Bit n of `ext_raise` sets vector n+16 pending.
- R6: The handler status word (offset 0x10) shows active flags and pending flags:
  - Active flags sit at bit 0 (memory-manage), bit 1 (bus), bit 3 (usage), bit 7 (SVC), bit 8 (debug), bit 10 (PendSV) and bit 11 (tick).
  - Pending flags sit at bit 12 (usage), bit 13 (memory-manage), bit 14 (bus) and bit 15 (SVC).
  - Enable bits sit at bit 16 (memory-manage), bit 17 (bus) and bit 18 (usage). These three bits are the only writable ones.
- R7: The vector base word (offset 0x08) stores bits [31:7] of a write, and its bits [6:0] read as 0.
- R8: A write to the reset-control word (offset 0x0C) acts only when bits [31:16] equal 0x05FA. With the key, bit 1 clears every active bit and bit 2 makes `sys_reset_req` high for exactly one cycle. Reads of this word return 0xFA050000.
- R9: A write to the trigger word (offset 0x14) sets external interrupt `wdata[8:0]` pending, but only when that number is below N_EXT.
- R10: Only accesses with `bus_size` == 2 (word) take effect. Any other size leaves all state unchanged and reads as 0.
- R11: The read data, and `sys_reset_req`, are registered. `bus_rdata` holds the value for the read presented at clock edge k from just after edge k until edge k+1. Pending/active updates made at edge k are visible on `pend_vec` right after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size, 2 = word |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_raise | input | 16 | Hardware set-pending, one bit per system vector |
| ext_raise | input | N_EXT | Hardware set-pending, one bit per external interrupt |
| cpu_active_vec | input | 9 | Vector the processor is running, 0 if none |
| ack | input | 1 | Take the offered pending vector |
| done | input | 1 | Retire `done_vec` |
| done_vec | input | 9 | Vector being retired |
| pend_vec | output | 9 | Offered pending vector |
| pend_valid | output | 1 | `pend_vec` is meaningful |
| sys_reset_req | output | 1 | One-cycle reset request |

## Verification
Every access is presented at a falling edge and is captured at the following rising edge. Read data is then due one rising edge later. The bench pushes the expected value into a queue when it issues the read, and the monitor pops and compares it at the next falling edge. Pending and active changes, `pend_vec` and `sys_reset_req` settle right after the edge that takes the write, `ack` or `done`. They are therefore sampled at the falling edge that closes that access, which leaves half a period of margin in both directions.

// File: rtl/exc_pkg.sv
// Package: shared vector numbers, register offsets and helpers for the
// exception register slice. Assumes at most 496 external interrupts (9-bit vectors).
package exc_pkg;
    localparam int VEC_W = 9;

    localparam int V_NMI   = 2;
    localparam int V_MEM   = 4;
    localparam int V_BUS   = 5;
    localparam int V_USAGE = 6;
    localparam int V_SVC   = 11;
    localparam int V_DEBUG = 12;
    localparam int V_PSV   = 14;
    localparam int V_TICK  = 15;
    localparam int V_EXT0  = 16;

    // Implemented system vectors: bits 2,4,5,6,11,12,14,15
    localparam logic [15:0] SYS_IMPL = 16'hD874;

    localparam logic [7:0] OFS_TYPE = 8'h00;
    localparam logic [7:0] OFS_CS   = 8'h04;
    localparam logic [7:0] OFS_BASE = 8'h08;
    localparam logic [7:0] OFS_RST  = 8'h0C;
    localparam logic [7:0] OFS_HSR  = 8'h10;
    localparam logic [7:0] OFS_TRIG = 8'h14;

    localparam logic [15:0] RST_KEY  = 16'h05FA;
    localparam logic [31:0] RST_READ = 32'hFA05_0000;
    localparam logic [1:0]  SZ_WORD  = 2'd2;
endpackage

// File: rtl/exc_pick.sv
// Module: lowest-number pending selector. Assumes req already holds only the
// pending bits that are enabled; vector 0 is never a valid request.
module exc_pick #(
    parameter int NVEC = 80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NVEC-1:0]           req,
    output logic [exc_pkg::VEC_W-1:0] vec,
    output logic                      valid
);
    // Scan from the top down so the lowest set bit is the one that remains.
    always_comb begin
        vec   = '0;
        valid = 1'b0;
        for (int i = NVEC - 1; i >= 0; i--) begin
            if (req[i]) begin
                vec   = exc_pkg::VEC_W'(i);
                valid = 1'b1;
            end
        end
    end

    a_r5_pick_is_request: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> req[vec]);
    a_r5_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req == '0));
endmodule

// File: rtl/exc_state.sv
// Module: pending and active bit arrays. Sets take precedence over clears,
// and an acknowledge takes precedence over a retire of the same vector.
module exc_state #(
    parameter int NVEC = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] set_pend,
    input  logic [NVEC-1:0] clr_pend,
    input  logic [NVEC-1:0] ack_oh,
    input  logic [NVEC-1:0] done_oh,
    input  logic            clr_all_act,
    output logic [NVEC-1:0] pend,
    output logic [NVEC-1:0] act
);
    // Pending array: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~(clr_pend | ack_oh)) | set_pend;
    end

    // Active array: retire or wipe, then mark the acknowledged vector.
    always_ff @(posedge clk) begin
        if (!rst_n)           act <= '0;
        else if (clr_all_act) act <= ack_oh;
        else                  act <= (act & ~done_oh) | ack_oh;
    end

    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend & $past(set_pend)) == $past(set_pend)));
    a_r5_ack_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((act & $past(ack_oh)) == $past(ack_oh)));
endmodule

// File: rtl/exc_csr.sv
// Module: register decode, write side effects and registered readback.
// Assumes one access per cycle; only word-size accesses take effect.
module exc_csr #(
    parameter int N_EXT = 64,
    parameter int NVEC  = 80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [1:0]                bus_size,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NVEC-1:0]           pend,
    input  logic [NVEC-1:0]           act,
    input  logic [exc_pkg::VEC_W-1:0] cpu_active_vec,
    input  logic [exc_pkg::VEC_W-1:0] pend_vec,
    input  logic                      pend_valid,
    output logic [NVEC-1:0]           sw_set,
    output logic [NVEC-1:0]           sw_clr,
    output logic                      clr_all_act,
    output logic [2:0]                fault_en,
    output logic                      sys_reset_req
);
    import exc_pkg::*;

    logic wr_ok, rd_ok, key_ok;
    logic [24:0] base_q;
    logic [31:0] cs_word, hsr_word, rd_mux;
    logic [NVEC-1:0] others_act;

    assign wr_ok  = bus_sel && bus_wr && (bus_size == SZ_WORD);
    assign rd_ok  = bus_sel && !bus_wr && (bus_size == SZ_WORD);
    assign key_ok = wr_ok && (bus_addr == OFS_RST) && (bus_wdata[31:16] == RST_KEY);

    // Software set/clear of pending bits from the control/state and trigger words.
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (wr_ok && bus_addr == OFS_CS) begin
            sw_set[V_NMI]  = bus_wdata[31];
            sw_set[V_PSV]  = bus_wdata[28];
            sw_clr[V_PSV]  = !bus_wdata[28] && bus_wdata[27];
            sw_set[V_TICK] = bus_wdata[26];
            sw_clr[V_TICK] = !bus_wdata[26] && bus_wdata[25];
        end
        if (wr_ok && bus_addr == OFS_TRIG && int'(bus_wdata[8:0]) < N_EXT)
            sw_set[V_EXT0 + int'(bus_wdata[8:0])] = 1'b1;
    end

    assign clr_all_act = key_ok && bus_wdata[1];

    // Writable state: fault enables and vector base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_en <= '0;
            base_q   <= '0;
        end else if (wr_ok) begin
            if (bus_addr == OFS_HSR)  fault_en <= bus_wdata[18:16];
            if (bus_addr == OFS_BASE) base_q   <= bus_wdata[31:7];
        end
    end

    // Keyed reset request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_reset_req <= 1'b0;
        else        sys_reset_req <= key_ok && bus_wdata[2];
    end

    assign others_act = act & ~(NVEC'(1) << cpu_active_vec);

    // Packed control/state and handler status words.
    always_comb begin
        cs_word        = '0;
        cs_word[8:0]   = cpu_active_vec;
        cs_word[20:12] = pend_valid ? pend_vec : '0;
        cs_word[11]    = (others_act == '0);
        cs_word[22]    = |pend[NVEC-1:V_EXT0];
        cs_word[26]    = pend[V_TICK];
        cs_word[28]    = pend[V_PSV];
        cs_word[31]    = pend[V_NMI];

        hsr_word        = '0;
        hsr_word[0]     = act[V_MEM];
        hsr_word[1]     = act[V_BUS];
        hsr_word[3]     = act[V_USAGE];
        hsr_word[7]     = act[V_SVC];
        hsr_word[8]     = act[V_DEBUG];
        hsr_word[10]    = act[V_PSV];
        hsr_word[11]    = act[V_TICK];
        hsr_word[12]    = pend[V_USAGE];
        hsr_word[13]    = pend[V_MEM];
        hsr_word[14]    = pend[V_BUS];
        hsr_word[15]    = pend[V_SVC];
        hsr_word[18:16] = fault_en;
    end

    // Read multiplexer by offset.
    always_comb begin
        case (bus_addr)
            OFS_TYPE: rd_mux = 32'((N_EXT / 32) - 1);
            OFS_CS:   rd_mux = cs_word;
            OFS_BASE: rd_mux = {base_q, 7'b0};
            OFS_RST:  rd_mux = RST_READ;
            OFS_HSR:  rd_mux = hsr_word;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data; non-word or idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_ok) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    a_r8_keyed_request: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> ($past(rst_n) && $past(bus_sel) && $past(bus_wr)
                           && $past(bus_wdata[31:16]) == RST_KEY && $past(bus_wdata[2])));
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req && !(key_ok && bus_wdata[2]) |=> !sys_reset_req);
    a_r10_narrow_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_size != SZ_WORD) |=> (bus_rdata == '0));
endmodule

// File: rtl/exc_ctrl_regs.sv
// Module: top of the exception register slice. Merges hardware and software
// pending sources, runs the selector and connects the processor strobes.
module exc_ctrl_regs #(
    parameter int N_EXT = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [1:0]                bus_size,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [15:0]               sys_raise,
    input  logic [N_EXT-1:0]          ext_raise,
    input  logic [exc_pkg::VEC_W-1:0] cpu_active_vec,
    input  logic                      ack,
    input  logic                      done,
    input  logic [exc_pkg::VEC_W-1:0] done_vec,
    output logic [exc_pkg::VEC_W-1:0] pend_vec,
    output logic                      pend_valid,
    output logic                      sys_reset_req
);
    import exc_pkg::*;
    localparam int NVEC = V_EXT0 + N_EXT;

    logic [NVEC-1:0] pend, act, sw_set, sw_clr, hw_set, ack_oh, done_oh, en_mask;
    logic [2:0]      fault_en;
    logic            clr_all_act;

    // Hardware raise lines: only implemented system vectors are accepted.
    assign hw_set = {ext_raise, sys_raise & SYS_IMPL};

    // Enable mask: only the three configurable faults can be gated.
    always_comb begin
        en_mask         = '1;
        en_mask[V_MEM]  = fault_en[0];
        en_mask[V_BUS]  = fault_en[1];
        en_mask[V_USAGE] = fault_en[2];
    end

    assign ack_oh  = (ack && pend_valid) ? (NVEC'(1) << pend_vec) : '0;
    assign done_oh = done ? (NVEC'(1) << done_vec) : '0;

    exc_pick #(.NVEC(NVEC)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(pend & en_mask),
        .vec(pend_vec), .valid(pend_valid)
    );

    exc_state #(.NVEC(NVEC)) u_state (
        .clk(clk), .rst_n(rst_n), .set_pend(hw_set | sw_set), .clr_pend(sw_clr),
        .ack_oh(ack_oh), .done_oh(done_oh), .clr_all_act(clr_all_act),
        .pend(pend), .act(act)
    );

    exc_csr #(.N_EXT(N_EXT), .NVEC(NVEC)) u_csr (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pend(pend), .act(act),
        .cpu_active_vec(cpu_active_vec), .pend_vec(pend_vec), .pend_valid(pend_valid),
        .sw_set(sw_set), .sw_clr(sw_clr), .clr_all_act(clr_all_act),
        .fault_en(fault_en), .sys_reset_req(sys_reset_req)
    );

    a_r5_ack_leaves_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_valid && !(hw_set[pend_vec] || sw_set[pend_vec]))
        |=> !pend[$past(pend_vec)]);
endmodule

// File: tb/test_exc_ctrl_regs.sv
// Bench: scoreboard. Read tasks queue expected data; a monitor pops and
// compares one falling edge after the capturing rising edge.
module test_exc_ctrl_regs;
    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [1:0]  bus_size = 2;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [15:0] sys_raise = 0;
    logic [63:0] ext_raise = 0;
    logic [8:0]  cpu_active_vec = 0, done_vec = 0, pend_vec;
    logic        ack = 0, done = 0, pend_valid, sys_reset_req;

    int n_checks = 0, n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        due = 0;

    always #2 clk = ~clk;

    exc_ctrl_regs #(.N_EXT(64)) i_exc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sys_raise(sys_raise), .ext_raise(ext_raise),
        .cpu_active_vec(cpu_active_vec), .ack(ack), .done(done), .done_vec(done_vec),
        .pend_vec(pend_vec), .pend_valid(pend_valid), .sys_reset_req(sys_reset_req)
    );

    task automatic check(input logic [31:0] act_v, input logic [31:0] exp_v, input string tag);
        n_checks++;
        if (act_v !== exp_v) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
        end
    endtask

    // Monitor: compare registered read data against the queue.
    always @(negedge clk) begin
        if (due) begin
            due = 0;
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_size = 2;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                      input logic [1:0] sz = 2);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk);
        #1 due = 1;
        @(negedge clk);
        bus_sel = 0; bus_size = 2;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1;
        @(posedge clk);
        @(negedge clk); ack = 0;
    endtask

    task automatic pulse_done(input logic [8:0] v);
        @(negedge clk); done = 1; done_vec = v;
        @(posedge clk);
        @(negedge clk); done = 0;
    endtask

    task automatic chk_pend(input logic vld, input logic [8:0] v, input string tag);
        check({22'b0, vld, v}, {22'b0, vld, (vld ? v : pend_vec)}, tag);
    endtask

    initial begin
        #80000;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        check({31'b0, pend_valid}, 32'h0, "R1 pend_valid after reset");
        rd(8'h04, 32'h0000_0800, "R1 control/state after reset");
        rd(8'h00, 32'h0000_0001, "R1 type word");

        // R2/R3 set PendSV and tick, set wins over clear
        wr(8'h04, 32'h1400_0000);
        rd(8'h04, 32'h1400_E800, "R3 PendSV+tick readback");
        wr(8'h04, 32'h1800_0000);
        rd(8'h04, 32'h1400_E800, "R2 set beats clear");
        wr(8'h04, 32'h0800_0000);
        rd(8'h04, 32'h0400_F800, "R2 PendSV cleared");
        wr(8'h04, 32'h0200_0000);
        rd(8'h04, 32'h0000_0800, "R2 tick cleared");

        // R2/R5 NMI, acknowledge and retire
        wr(8'h04, 32'h8000_0000);
        check({23'b0, pend_vec}, 32'd2, "R5 NMI offered");
        rd(8'h04, 32'h8000_2800, "R3 NMI pending readback");
        pulse_ack();
        cpu_active_vec = 2;
        check({31'b0, pend_valid}, 32'h0, "R5 ack empties pending");
        rd(8'h04, 32'h0000_0802, "R4 only current active");
        pulse_done(2);
        cpu_active_vec = 0;
        rd(8'h04, 32'h0000_0800, "R5 NMI retired");

        // R5/R6 enable gating of memory-manage
        @(negedge clk) sys_raise = 16'h0018;
        @(negedge clk) sys_raise = 0;
        check({31'b0, pend_valid}, 32'h0, "R5 disabled fault not offered");
        rd(8'h10, 32'h0000_2000, "R6 mem pending flag");
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0007_2000, "R6 only enables writable");
        check({22'b0, pend_valid, pend_vec}, {22'b0, 1'b1, 9'd4}, "R5 enabled fault offered");

        // R9 software trigger
        wr(8'h14, 32'd70);
        check({22'b0, pend_valid, pend_vec}, {22'b0, 1'b1, 9'd4}, "R9 out-of-range ignored");
        rd(8'h04, 32'h0000_4800, "R9 out-of-range no external pending");
        wr(8'h14, 32'd5);
        pulse_ack();
        cpu_active_vec = 4;
        rd(8'h10, 32'h0007_0001, "R6 mem active flag");
        check({22'b0, pend_valid, pend_vec}, {22'b0, 1'b1, 9'd21}, "R9 external 5 is vector 21");
        rd(8'h04, 32'h0041_5804, "R3 active, pending, external flag");
        pulse_ack();
        cpu_active_vec = 21;
        rd(8'h04, 32'h0000_0015, "R4 nested active clears flag");

        // R8 keyed reset-control
        wr(8'h0C, 32'h1234_0002);
        rd(8'h04, 32'h0000_0015, "R8 bad key ignored");
        wr(8'h0C, 32'h05FA_0002);
        rd(8'h04, 32'h0000_0815, "R8 key clears active");
        wr(8'h0C, 32'h05FA_0004);
        check({31'b0, sys_reset_req}, 32'h1, "R8 reset request pulse");
        @(negedge clk);
        check({31'b0, sys_reset_req}, 32'h0, "R8 pulse lasts one cycle");
        rd(8'h0C, 32'hFA05_0000, "R8 readback constant");
        cpu_active_vec = 0;

        // R7 vector base, R10 narrow accesses
        wr(8'h08, 32'h1234_5FFF);
        rd(8'h08, 32'h1234_5F80, "R7 low bits dropped");
        wr(8'h08, 32'hFFFF_FFFF, 2'd1);
        rd(8'h08, 32'h1234_5F80, "R10 narrow write ignored");
        rd(8'h08, 32'h0, "R10 narrow read zero", 2'd0);

        // R5/R11 hardware external raise, lowest wins
        @(negedge clk) ext_raise[63] = 1; ext_raise[10] = 1;
        @(negedge clk) ext_raise = 0;
        check({22'b0, pend_valid, pend_vec}, {22'b0, 1'b1, 9'd26}, "R11 raise visible next edge");
        pulse_ack();
        check({22'b0, pend_valid, pend_vec}, {22'b0, 1'b1, 9'd79}, "R5 highest external next");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule